// File: doc/BRIEF.md
# Reconfigurable Processing Element ALU

This block is one cell of a coarse-grained reconfigurable compute array. It captures two 16-bit operands into its A and B operand registers, keeps a third operand in a C register, and writes the outcome of one of 26 logic and arithmetic operations into a result register. The operation is chosen by a 5-bit operation code loaded from configuration. Routing between cells, FIFOs and context storage sit outside the block.

The opcode space is laid out so that the highest set bit of a code names the sub-circuit that runs it:

| Code bits | Unit |
|---|---|
| bit 4 set | arithmetic, codes 16 to 25 |
| bit 3 highest | logic, codes 8 to 15 |
| bit 2 highest | shift, codes 4 to 7 |
| bit 1 highest | compare, codes 2 and 3 |
| code 1 | move |
| code 0 | zero |

Each unit keeps its own small configuration register. That register loads only when its bit of the loaded opcode is one, so a zero bit holds that unit's configuration still and its logic does not toggle. Codes 26 to 31 are reserved.

A build-time parameter decides whether the cell contains a 16x16 multiplier. Cells built without one flag any multiply request as illegal, which lets an array mix cells with and without multipliers.

Top module: `pe_cell`

## Requirements
- R1: After reset, res_o, res_vld_o and ill_o are 0, and the selected operation is code 0 (zero result). An operand strobe with no prior configuration load therefore yields 0 with res_vld_o high.
- R2: On a clock edge with cfg_load_i high, cfg_op_i becomes the active opcode. On an edge with in_vld_i high, a_i and b_i are captured. On the following edge, res_o and ill_o are updated and res_vld_o rises for one cycle. Without an operand strobe, res_o and ill_o hold, including across a configuration load.
- R3: Logic codes on A and B: 8 NOT A, 9 AND, 10 OR, 11 XOR, 12 NAND, 13 NOR, 14 XNOR, 15 A AND NOT B.
- R4: Shift codes shift A by B[3:0]: 4 left logical, 5 right logical, 6 right arithmetic, 7 rotate left.
- R5: Code 0 gives 0 and code 1 gives A. Code 2 gives 1 when signed A < signed B and 0 otherwise. Code 3 gives 1 when A equals B and 0 otherwise.
- R6: Code 16 is A+B and code 17 is A-B, both wrapping modulo 2^16. Code 22 is the signed minimum and code 23 the signed maximum.
- R7: Saturating codes clamp the exact signed result to the range -32768 to 32767: 18 A+B, 19 A-B, 20 absolute value of A, 21 absolute value of A-B. The absolute value of -32768 gives 32767.
- R8: With HAS_MULT=1, code 24 gives the low 16 bits of the product A*B and code 25 gives the low 16 bits of A*B+C, with ill_o low.
- R9: With HAS_MULT=0, codes 24 and 25 give 0 and set ill_o to 1. All other codes behave as with the multiplier.
- R10: Reserved codes 26 to 31 leave res_o unchanged on an operand strobe and set ill_o to 1. Any legal code clears ill_o on its result.
- R11: A unit's configuration register changes only on a load whose opcode has that unit's bit set: bit 1 for compare, bit 2 for shift, bit 3 for logic, bit 4 for arithmetic. Switching among units in any order gives correct results.
- R12: The C register loads c_i on an edge with c_load_i high and otherwise keeps its value for later code-25 operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load strobe for a new opcode |
| cfg_op_i | input | 5 | Opcode to load |
| in_vld_i | input | 1 | Operand strobe, captures A and B |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| c_load_i | input | 1 | Load strobe for the C register |
| c_i | input | 16 | Value for the C register |
| res_o | output | 16 | Result register |
| res_vld_o | output | 1 | High for one cycle after a new result |
| ill_o | output | 1 | Illegal operation flag for the last result |

## Verification
The properties assume that cfg_op_i is a known value whenever cfg_load_i is high, and that the strobes are never unknown out of reset. The gating properties look only at the direction in which a zero opcode bit must hold a unit's configuration still. The stimulus changes every input on falling edges only and holds it for exactly one cycle. It always sets or clears each strobe explicitly, so no edge sees a partial configuration or operand word.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int OP_W  = 5;
  localparam int N_OPS = 26;

  typedef enum logic [2:0] {
    U_ZERO = 3'd0,
    U_MOV  = 3'd1,
    U_CMP  = 3'd2,
    U_SHF  = 3'd3,
    U_LOG  = 3'd4,
    U_ARI  = 3'd5,
    U_RSV  = 3'd6
  } unit_e;

  // highest set opcode bit selects the unit
  function automatic unit_e unit_of(input logic [OP_W-1:0] op);
    unit_e u;
    if (int'(op) >= N_OPS) u = U_RSV;
    else if (op[4])        u = U_ARI;
    else if (op[3])        u = U_LOG;
    else if (op[2])        u = U_SHF;
    else if (op[1])        u = U_CMP;
    else if (op[0])        u = U_MOV;
    else                   u = U_ZERO;
    return u;
  endfunction
endpackage

// File: rtl/pe_cfg.sv
module pe_cfg
  import pe_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_load_i,
  input  logic [OP_W-1:0] cfg_op_i,
  output unit_e           sel_o,
  output logic            cmp_cfg_o,
  output logic [1:0]      shf_cfg_o,
  output logic [2:0]      log_cfg_o,
  output logic [3:0]      ari_cfg_o
);
  unit_e nxt_unit;
  assign nxt_unit = unit_of(cfg_op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_o <= U_ZERO;
    else if (cfg_load_i) sel_o <= nxt_unit;
  end

  // per-unit config registers: each loads only for its own unit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_cfg_o <= 1'b0;
    else if (cfg_load_i && nxt_unit == U_CMP) cmp_cfg_o <= cfg_op_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shf_cfg_o <= '0;
    else if (cfg_load_i && nxt_unit == U_SHF) shf_cfg_o <= cfg_op_i[1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) log_cfg_o <= '0;
    else if (cfg_load_i && nxt_unit == U_LOG) log_cfg_o <= cfg_op_i[2:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ari_cfg_o <= '0;
    else if (cfg_load_i && nxt_unit == U_ARI) ari_cfg_o <= cfg_op_i[3:0];
  end
endmodule

// File: rtl/pe_bitops.sv
module pe_bitops #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cmp_cfg_i,
  input  logic [1:0]   shf_cfg_i,
  input  logic [2:0]   log_cfg_i,
  output logic [W-1:0] cmp_res_o,
  output logic [W-1:0] shf_res_o,
  output logic [W-1:0] log_res_o
);
  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] sh;
  logic [2*W-1:0]  dbl;
  logic            cmp_bit;

  assign sh  = b_i[SH_W-1:0];
  assign dbl = {a_i, a_i} << sh;

  assign cmp_bit   = cmp_cfg_i ? (a_i == b_i) : ($signed(a_i) < $signed(b_i));
  assign cmp_res_o = {{(W-1){1'b0}}, cmp_bit};

  always_comb begin
    unique case (shf_cfg_i)
      2'd0:    shf_res_o = dbl[W-1:0];
      2'd1:    shf_res_o = a_i >> sh;
      2'd2:    shf_res_o = W'($signed(a_i) >>> sh);
      default: shf_res_o = dbl[2*W-1:W];
    endcase
  end

  always_comb begin
    unique case (log_cfg_i)
      3'd0:    log_res_o = ~a_i;
      3'd1:    log_res_o = a_i & b_i;
      3'd2:    log_res_o = a_i | b_i;
      3'd3:    log_res_o = a_i ^ b_i;
      3'd4:    log_res_o = ~(a_i & b_i);
      3'd5:    log_res_o = ~(a_i | b_i);
      3'd6:    log_res_o = ~(a_i ^ b_i);
      default: log_res_o = a_i & ~b_i;
    endcase
  end
endmodule

// File: rtl/pe_arith.sv
module pe_arith #(
  parameter int W        = 16,
  parameter bit HAS_MULT = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [3:0]   ari_cfg_i,
  output logic [W-1:0] res_o,
  output logic         mult_ill_o
);
  localparam int XW = W + 2;
  typedef logic signed [XW-1:0] xw_t;
  localparam xw_t SMAX = {3'b000, {(W-1){1'b1}}};
  localparam xw_t SMIN = {3'b111, {(W-1){1'b0}}};

  function automatic logic [W-1:0] sat(input xw_t v);
    if (v > SMAX)      return SMAX[W-1:0];
    else if (v < SMIN) return SMIN[W-1:0];
    else               return v[W-1:0];
  endfunction

  xw_t sa, sb, sum, dif, abs_a, abs_d;
  logic         lt;
  logic [W-1:0] mul_lo;
  logic         is_mul;

  assign sa    = {{2{a_i[W-1]}}, a_i};
  assign sb    = {{2{b_i[W-1]}}, b_i};
  assign sum   = sa + sb;
  assign dif   = sa - sb;
  assign abs_a = sa[XW-1]  ? -sa  : sa;
  assign abs_d = dif[XW-1] ? -dif : dif;
  assign lt    = $signed(a_i) < $signed(b_i);

  generate
    if (HAS_MULT) begin : g_mult
      assign mul_lo = a_i * b_i;
    end else begin : g_no_mult
      assign mul_lo = '0;
    end
  endgenerate

  assign is_mul     = (ari_cfg_i == 4'd8) || (ari_cfg_i == 4'd9);
  assign mult_ill_o = !HAS_MULT && is_mul;

  always_comb begin
    res_o = '0;
    if (!mult_ill_o) begin
      unique case (ari_cfg_i)
        4'd0:    res_o = sum[W-1:0];
        4'd1:    res_o = dif[W-1:0];
        4'd2:    res_o = sat(sum);
        4'd3:    res_o = sat(dif);
        4'd4:    res_o = sat(abs_a);
        4'd5:    res_o = sat(abs_d);
        4'd6:    res_o = lt ? a_i : b_i;
        4'd7:    res_o = lt ? b_i : a_i;
        4'd8:    res_o = mul_lo;
        4'd9:    res_o = mul_lo + c_i;
        default: res_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pe_cell.sv
module pe_cell
  import pe_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter bit HAS_MULT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [OP_W-1:0]   cfg_op_i,
  input  logic              in_vld_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c_load_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_vld_o,
  output logic              ill_o
);
  unit_e             sel;
  logic              cmp_cfg;
  logic [1:0]        shf_cfg;
  logic [2:0]        log_cfg;
  logic [3:0]        ari_cfg;
  logic [DATA_W-1:0] a_q, b_q, c_q;
  logic              vld_q;
  logic [DATA_W-1:0] cmp_res, shf_res, log_res, ari_res;
  logic              mult_ill;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_ill;

  pe_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_load_i (cfg_load_i),
    .cfg_op_i   (cfg_op_i),
    .sel_o      (sel),
    .cmp_cfg_o  (cmp_cfg),
    .shf_cfg_o  (shf_cfg),
    .log_cfg_o  (log_cfg),
    .ari_cfg_o  (ari_cfg)
  );

  // operand registers A, B and C
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_vld_i;
      if (in_vld_i) begin
        a_q <= a_i;
        b_q <= b_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) c_q <= '0;
    else if (c_load_i) c_q <= c_i;
  end

  pe_bitops #(.W(DATA_W)) u_bit (
    .a_i       (a_q),
    .b_i       (b_q),
    .cmp_cfg_i (cmp_cfg),
    .shf_cfg_i (shf_cfg),
    .log_cfg_i (log_cfg),
    .cmp_res_o (cmp_res),
    .shf_res_o (shf_res),
    .log_res_o (log_res)
  );

  pe_arith #(.W(DATA_W), .HAS_MULT(HAS_MULT)) u_ari (
    .a_i        (a_q),
    .b_i        (b_q),
    .c_i        (c_q),
    .ari_cfg_i  (ari_cfg),
    .res_o      (ari_res),
    .mult_ill_o (mult_ill)
  );

  always_comb begin
    nxt_ill = 1'b0;
    unique case (sel)
      U_ZERO:  nxt_res = '0;
      U_MOV:   nxt_res = a_q;
      U_CMP:   nxt_res = cmp_res;
      U_SHF:   nxt_res = shf_res;
      U_LOG:   nxt_res = log_res;
      U_ARI: begin
        nxt_res = ari_res;
        nxt_ill = mult_ill;
      end
      default: begin
        nxt_res = res_o;
        nxt_ill = 1'b1;
      end
    endcase
  end

  // temporary-result register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      ill_o     <= 1'b0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= vld_q;
      if (vld_q) begin
        res_o <= nxt_res;
        ill_o <= nxt_ill;
      end
    end
  end
endmodule

// File: rtl/pe_cell_chk.sv
module pe_cell_chk
  import pe_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter bit HAS_MULT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_load_i,
  input logic [OP_W-1:0]   cfg_op_i,
  input logic              vld_q,
  input unit_e             sel,
  input logic              cmp_cfg,
  input logic [1:0]        shf_cfg,
  input logic [2:0]        log_cfg,
  input logic [3:0]        ari_cfg,
  input logic [DATA_W-1:0] res_o,
  input logic              res_vld_o,
  input logic              ill_o
);
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |-> $stable(res_o) && $stable(ill_o)); // R2
  AST_RESERVED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && sel == U_RSV |=> $stable(res_o) && ill_o); // R10
  AST_ILL_WITH_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ill_o) |-> res_vld_o); // R10
  AST_NO_MULT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_MULT && vld_q && sel == U_ARI && ari_cfg[3] |=> res_o == '0 && ill_o); // R9
  AST_GATE_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i && !cfg_op_i[1] |=> $stable(cmp_cfg)); // R11
  AST_GATE_SHF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i && !cfg_op_i[2] |=> $stable(shf_cfg)); // R11
  AST_GATE_LOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i && !cfg_op_i[3] |=> $stable(log_cfg)); // R11
  AST_GATE_ARI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i && !cfg_op_i[4] |=> $stable(ari_cfg)); // R11
endmodule

bind pe_cell pe_cell_chk #(.DATA_W(DATA_W), .HAS_MULT(HAS_MULT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_load_i (cfg_load_i),
  .cfg_op_i   (cfg_op_i),
  .vld_q      (vld_q),
  .sel        (sel),
  .cmp_cfg    (cmp_cfg),
  .shf_cfg    (shf_cfg),
  .log_cfg    (log_cfg),
  .ari_cfg    (ari_cfg),
  .res_o      (res_o),
  .res_vld_o  (res_vld_o),
  .ill_o      (ill_o)
);

// File: tb/sim_pe_cell.sv
`timescale 1ns/1ps
module sim_pe_cell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [4:0]  cfg_op = '0;
  logic        in_vld = 1'b0;
  logic [15:0] a = '0, b = '0, c = '0;
  logic        c_load = 1'b0;
  logic [15:0] res0, res1;
  logic        vld0, vld1, ill0, ill1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pe_cell #(.DATA_W(16), .HAS_MULT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_op_i(cfg_op),
    .in_vld_i(in_vld), .a_i(a), .b_i(b), .c_load_i(c_load), .c_i(c),
    .res_o(res0), .res_vld_o(vld0), .ill_o(ill0));

  pe_cell #(.DATA_W(16), .HAS_MULT(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_op_i(cfg_op),
    .in_vld_i(in_vld), .a_i(a), .b_i(b), .c_load_i(c_load), .c_i(c),
    .res_o(res1), .res_vld_o(vld1), .ill_o(ill1));

  typedef struct packed {
    logic [4:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] c;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [0:NV-1] = '{
    '{5'd8,  16'h1234, 16'h0F0F, 16'h0000, 16'hEDCB},
    '{5'd9,  16'h1234, 16'h0F0F, 16'h0000, 16'h0204},
    '{5'd10, 16'h1234, 16'h0F0F, 16'h0000, 16'h1F3F},
    '{5'd11, 16'h1234, 16'h0F0F, 16'h0000, 16'h1D3B},
    '{5'd12, 16'h1234, 16'h0F0F, 16'h0000, 16'hFDFB},
    '{5'd13, 16'h1234, 16'h0F0F, 16'h0000, 16'hE0C0},
    '{5'd14, 16'h1234, 16'h0F0F, 16'h0000, 16'hE2C4},
    '{5'd15, 16'h1234, 16'h0F0F, 16'h0000, 16'h1030},
    '{5'd4,  16'h8421, 16'h0004, 16'h0000, 16'h4210},
    '{5'd5,  16'h8421, 16'h0004, 16'h0000, 16'h0842},
    '{5'd6,  16'h8421, 16'h0004, 16'h0000, 16'hF842},
    '{5'd7,  16'h8421, 16'h0004, 16'h0000, 16'h4218},
    '{5'd4,  16'h8421, 16'h0013, 16'h0000, 16'h2108},
    '{5'd0,  16'h5555, 16'h0001, 16'h0000, 16'h0000},
    '{5'd1,  16'hBEEF, 16'h0001, 16'h0000, 16'hBEEF},
    '{5'd2,  16'hFFFF, 16'h0001, 16'h0000, 16'h0001},
    '{5'd2,  16'h0005, 16'h0005, 16'h0000, 16'h0000},
    '{5'd3,  16'h0005, 16'h0005, 16'h0000, 16'h0001},
    '{5'd3,  16'h0005, 16'h0006, 16'h0000, 16'h0000},
    '{5'd16, 16'h7FFF, 16'h0001, 16'h0000, 16'h8000},
    '{5'd17, 16'h0000, 16'h0001, 16'h0000, 16'hFFFF},
    '{5'd18, 16'h7FFF, 16'h0001, 16'h0000, 16'h7FFF},
    '{5'd18, 16'h8000, 16'hFFFF, 16'h0000, 16'h8000},
    '{5'd18, 16'h0064, 16'h00C8, 16'h0000, 16'h012C},
    '{5'd19, 16'h8000, 16'h0001, 16'h0000, 16'h8000},
    '{5'd19, 16'h7FFF, 16'hFFFF, 16'h0000, 16'h7FFF},
    '{5'd20, 16'h8000, 16'h0000, 16'h0000, 16'h7FFF},
    '{5'd20, 16'hFFFB, 16'h0000, 16'h0000, 16'h0005},
    '{5'd21, 16'h7FFF, 16'h8000, 16'h0000, 16'h7FFF},
    '{5'd21, 16'h0003, 16'h000A, 16'h0000, 16'h0007},
    '{5'd22, 16'hFFFF, 16'h0001, 16'h0000, 16'hFFFF},
    '{5'd23, 16'hFFFF, 16'h0001, 16'h0000, 16'h0001},
    '{5'd24, 16'h0100, 16'h0100, 16'h0000, 16'h0000},
    '{5'd24, 16'hFFFE, 16'h0003, 16'h0000, 16'hFFFA},
    '{5'd24, 16'd300,  16'd7,    16'h0000, 16'h0834},
    '{5'd25, 16'h0003, 16'h0004, 16'h0010, 16'h001C},
    '{5'd16, 16'h0001, 16'h0002, 16'h0000, 16'h0003}
  };

  function automatic string tag_of(input logic [4:0] op);
    if (op >= 5'd24 && op <= 5'd25) return "R8";
    if (op >= 5'd18 && op <= 5'd21) return "R7";
    if (op >= 5'd16)                return "R6";
    if (op >= 5'd8)                 return "R3";
    if (op >= 5'd4)                 return "R4";
    return "R5";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // load opcode and operands together; result checked two edges later
  task automatic run(input logic [4:0] op, input logic [15:0] va, input logic [15:0] vb,
                     input logic [15:0] vc, input logic cld);
    @(negedge clk);
    cfg_load = 1'b1; cfg_op = op; in_vld = 1'b1; a = va; b = vb;
    c_load = cld; c = vc;
    @(negedge clk);
    cfg_load = 1'b0; in_vld = 1'b0; c_load = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {res0, vld0, ill0}, {16'h0000, 1'b0, 1'b0});
    rst_n = 1'b1;
    // R1: default op is zero without any configuration load
    @(negedge clk);
    in_vld = 1'b1; a = 16'h1234; b = 16'h4321;
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    chk("R1 default op", {res0, vld0, ill0}, {16'h0000, 1'b1, 1'b0});

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].c, 1'b1);
      chk(tag_of(VECS[i].op), {res0, vld0, ill0}, {VECS[i].exp, 1'b1, 1'b0});
    end

    // R2: result and valid pulse hold when no operand strobe follows
    @(negedge clk);
    chk("R2 hold", {res0, vld0}, {16'h0003, 1'b0});
    @(negedge clk);
    cfg_load = 1'b1; cfg_op = 5'd11;
    @(negedge clk);
    cfg_load = 1'b0;
    @(negedge clk);
    chk("R2 cfg only", {res0, vld0, ill0}, {16'h0003, 1'b0, 1'b0});
    // R2: operands after a separate config load use the new op
    in_vld = 1'b1; a = 16'h00FF; b = 16'h0F0F;
    @(negedge clk);
    in_vld = 1'b0;
    chk("R2 latency", {res0, vld0}, {16'h0003, 1'b0});
    @(negedge clk);
    chk("R2 new op", {res0, vld0}, {16'h0FF0, 1'b1});

    // R10: reserved codes keep the result and flag
    run(5'd16, 16'h0001, 16'h0002, 16'h0000, 1'b0);
    run(5'd26, 16'h0009, 16'h0009, 16'h0000, 1'b0);
    chk("R10 code 26", {res0, vld0, ill0}, {16'h0003, 1'b1, 1'b1});
    run(5'd31, 16'h0777, 16'h0001, 16'h0000, 1'b0);
    chk("R10 code 31", {res0, vld0, ill0}, {16'h0003, 1'b1, 1'b1});
    run(5'd1, 16'hCAFE, 16'h0000, 16'h0000, 1'b0);
    chk("R10 flag clears", {res0, ill0}, {16'hCAFE, 1'b0});

    // R12: C held when c_load_i is low
    run(5'd25, 16'h0003, 16'h0004, 16'h0010, 1'b1);
    chk("R12 load", {res0, ill0}, {16'h001C, 1'b0});
    run(5'd25, 16'h0002, 16'h0005, 16'h0099, 1'b0);
    chk("R12 hold", {res0, ill0}, {16'h001A, 1'b0});

    // R9: cell without multiplier
    run(5'd24, 16'd300, 16'd7, 16'h0000, 1'b0);
    chk("R8 with mult", {res0, ill0}, {16'h0834, 1'b0});
    chk("R9 mul", {res1, vld1, ill1}, {16'h0000, 1'b1, 1'b1});
    run(5'd25, 16'h0003, 16'h0004, 16'h0010, 1'b1);
    chk("R9 mac", {res1, ill1}, {16'h0000, 1'b1});
    run(5'd18, 16'h7FFF, 16'h0001, 16'h0000, 1'b0);
    chk("R9 other op", {res1, ill1}, {16'h7FFF, 1'b0});

    // R11: hopping between units in mixed order
    run(5'd9,  16'h00FF, 16'h0F0F, 16'h0000, 1'b0);
    chk("R11 logic", res0, 16'h000F);
    run(5'd0,  16'h1111, 16'h2222, 16'h0000, 1'b0);
    chk("R11 zero", res0, 16'h0000);
    run(5'd6,  16'h8000, 16'h0002, 16'h0000, 1'b0);
    chk("R11 shift", res0, 16'hE000);
    run(5'd3,  16'h0042, 16'h0042, 16'h0000, 1'b0);
    chk("R11 cmp", res0, 16'h0001);
    run(5'd17, 16'h0010, 16'h0003, 16'h0000, 1'b0);
    chk("R11 arith", res0, 16'h000D);
    run(5'd13, 16'h0F00, 16'h00F0, 16'h0000, 1'b0);
    chk("R11 logic again", res0, 16'hF00F);

    // R1: mid-run reset clears the outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset again", {res0, vld0, ill0}, {16'h0000, 1'b0, 1'b0});
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule